// File: doc/BRIEF.md
# Package Sleep Coordinator

This block decides when a whole multi-core package may enter a deep sleep state in which every package clock is stopped. It watches one halt indication per core together with a package-level automatic-sleep enable. When all cores have reported halt for long enough and the enable is set, it puts the package to sleep with no software action. Software can also request the same deep sleep directly, whatever the cores are doing at the time.

The package leaves sleep when a wake event arrives or when any core drops its halt indication. All clocks come back on the clock edge that follows. A 2-bit mode output shows whether the package is active, asleep because of the automatic path, or asleep because software asked for it. A single clock-off output tells the clock tree to stop everything. The core count and the width of the dwell setting are parameters. The dwell length itself is an input.

Top module: `pkg_sleep_ctrl`

## Requirements
- R1: While reset is asserted, mode_o is 0 (active) and clk_off_o is 0. The asynchronous reset is released through a two-stage synchroniser.
- R2: With dwell_i = D (0 to 15), mode_o becomes 1 (auto-sleep) at the clock edge that ends the (D+1)th consecutive qualifying cycle. A cycle qualifies when it is active, every bit of halt_i is 1, auto_en_i is 1 and wake_i is 0.
- R3: A cycle that does not qualify sets the consecutive count back to zero. After that, a full D+1 new qualifying cycles are needed.
- R4: While auto_en_i is 0, the block never enters auto-sleep, even with all cores halted.
- R5: In active mode, sw_sleep_i = 1 with wake_i = 0 moves mode_o to 2 (commanded sleep) at the next edge, whatever the value of halt_i.
- R6: If the command and the automatic condition occur in the same cycle, the command wins and mode_o becomes 2.
- R7: wake_i = 1 returns either sleep mode to 0 at the next edge. In active mode it blocks both entry paths for that cycle.
- R8: While asleep, any halt_i bit falling from 1 to 0 returns mode_o to 0 at the next edge. A rising halt bit has no effect, and neither does clearing auto_en_i.
- R9: sw_sleep_i has no effect while the package is already asleep.
- R10: clk_off_o is 1 exactly when mode_o is non-zero. mode_o never takes the value 3.
- R11: The consecutive count is held at zero while the package is asleep. Re-entry after a wake therefore needs the full dwell again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Package clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | NCORES | Per-core halt indication, 1 = halted |
| auto_en_i | input | 1 | Enables automatic package sleep |
| dwell_i | input | DWELL_W | Extra qualifying cycles required before automatic entry |
| sw_sleep_i | input | 1 | Software request for commanded sleep |
| wake_i | input | 1 | Wake or interrupt event |
| clk_off_o | output | 1 | Stop all package clocks |
| mode_o | output | 2 | 0 active, 1 auto-sleep, 2 commanded sleep |

## Verification
A wrong mode register shows up on mode_o and clk_off_o at the first edge after the faulty transition, because both outputs come straight from flops. A corrupted dwell count stays hidden until the next automatic entry, which then lands one or more edges early or late. The stimulus therefore checks entry at exact cycle positions, including dwell 0 and dwell 15. A stale per-core halt history only shows during sleep: a missed falling edge leaves mode_o stuck non-zero, and a phantom fall wakes the package one cycle after a rising halt.

// File: rtl/pkg_sleep_pkg.sv
package pkg_sleep_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_CMD    = 2'd2
  } pkg_mode_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/halt_edge_mon.sv
module halt_edge_mon #(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCORES-1:0] halt_i,
  output logic              all_halted_o,
  output logic              any_fall_o
);
  logic [NCORES-1:0] halt_q;
  logic [NCORES-1:0] fall_v;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt_q[c] <= 1'b0;
      else        halt_q[c] <= halt_i[c];
    end
    assign fall_v[c] = halt_q[c] & ~halt_i[c];
  end

  assign all_halted_o = &halt_i;
  assign any_fall_o   = |fall_v;
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         qual_i,
  input  logic [W-1:0] limit_i,
  output logic         reached_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign reached_o = qual_i && (cnt_q >= limit_i);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import pkg_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_go_i,
  input  logic       cmd_i,
  input  logic       wake_i,
  input  logic       core_fall_i,
  output logic [1:0] mode_o,
  output logic       clk_off_o,
  output logic       active_o
);
  pkg_mode_e state_q;
  pkg_mode_e state_d;
  logic      off_q;
  logic      off_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_ACTIVE: begin
        if (!wake_i) begin
          if (cmd_i)          state_d = MODE_CMD;
          else if (auto_go_i) state_d = MODE_AUTO;
        end
      end
      MODE_AUTO, MODE_CMD: begin
        if (wake_i || core_fall_i) state_d = MODE_ACTIVE;
      end
      default: state_d = MODE_ACTIVE;
    endcase
    off_d = (state_d != MODE_ACTIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_ACTIVE;
      off_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
    end
  end

  assign mode_o    = state_q;
  assign clk_off_o = off_q;
  assign active_o  = (state_q == MODE_ACTIVE);
endmodule

// File: rtl/pkg_sleep_ctrl.sv
module pkg_sleep_ctrl #(
  parameter int NCORES  = 4,
  parameter int DWELL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCORES-1:0]  halt_i,
  input  logic               auto_en_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               sw_sleep_i,
  input  logic               wake_i,
  output logic               clk_off_o,
  output logic [1:0]         mode_o
);
  logic rst_sync_n;
  logic all_halted;
  logic any_fall;
  logic qual;
  logic active;
  logic auto_go;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  halt_edge_mon #(.NCORES(NCORES)) u_mon (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .halt_i       (halt_i),
    .all_halted_o (all_halted),
    .any_fall_o   (any_fall)
  );

  assign qual = all_halted & auto_en_i & ~wake_i & active;

  dwell_timer #(.W(DWELL_W)) u_dwell (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_i   (~qual),
    .qual_i    (qual),
    .limit_i   (dwell_i),
    .reached_o (auto_go)
  );

  sleep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .auto_go_i   (auto_go),
    .cmd_i       (sw_sleep_i),
    .wake_i      (wake_i),
    .core_fall_i (any_fall),
    .mode_o      (mode_o),
    .clk_off_o   (clk_off_o),
    .active_o    (active)
  );
endmodule

// File: rtl/pkg_sleep_chk.sv
module pkg_sleep_chk #(
  parameter int NCORES = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [NCORES-1:0] halt_i,
  input logic              auto_en_i,
  input logic              sw_sleep_i,
  input logic              wake_i,
  input logic              clk_off_o,
  input logic [1:0]        mode_o
);
  assert_clkoff_match_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clk_off_o == (mode_o != 2'd0));

  assert_no_mode3_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_o != 2'd3);

  assert_no_auto_when_off_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_o == 2'd0 && !auto_en_i && !sw_sleep_i) |=> mode_o == 2'd0);

  assert_cmd_entry_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_o == 2'd0 && sw_sleep_i && !wake_i) |=> mode_o == 2'd2);

  assert_wake_exit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_i |=> mode_o == 2'd0);

  assert_auto_exit_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_o == 2'd1 && !(&halt_i)) |=> mode_o == 2'd0);

  assert_auto_needs_halt_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_o == 2'd0 && !(&halt_i) && !sw_sleep_i) |=> mode_o == 2'd0);
endmodule

bind pkg_sleep_ctrl pkg_sleep_chk #(.NCORES(NCORES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .halt_i     (halt_i),
  .auto_en_i  (auto_en_i),
  .sw_sleep_i (sw_sleep_i),
  .wake_i     (wake_i),
  .clk_off_o  (clk_off_o),
  .mode_o     (mode_o)
);

// File: tb/sim_pkg_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pkg_sleep_ctrl;
  localparam int NC = 4;
  localparam int NV = 27;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] halt_i;
  logic          auto_en_i;
  logic [3:0]    dwell_i;
  logic          sw_sleep_i;
  logic          wake_i;
  logic          clk_off_o;
  logic [1:0]    mode_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pkg_sleep_ctrl #(.NCORES(NC), .DWELL_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .auto_en_i(auto_en_i),
    .dwell_i(dwell_i), .sw_sleep_i(sw_sleep_i), .wake_i(wake_i),
    .clk_off_o(clk_off_o), .mode_o(mode_o)
  );

  // fields: halt[12:9] en[8] dwell[7:4] sw[3] wake[2] expected mode[1:0]
  localparam logic [12:0] VEC [NV] = '{
    {4'b1111, 1'b0, 4'd2, 1'b0, 1'b0, 2'd0},  // R4 disabled
    {4'b1111, 1'b0, 4'd2, 1'b0, 1'b0, 2'd0},  // R4
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R2 count 1
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R2 count 2
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd1},  // R2 enter
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd1},  // R2 stay
    {4'b1011, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R8 core leaves halt
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R11 restart
    {4'b1110, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R3 dropout
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R3
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},  // R3
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b0, 2'd1},  // R3 enter after full dwell
    {4'b1111, 1'b1, 4'd2, 1'b0, 1'b1, 2'd0},  // R7 wake from auto
    {4'b1111, 1'b1, 4'd0, 1'b0, 1'b0, 2'd1},  // R2 dwell 0
    {4'b1111, 1'b1, 4'd0, 1'b1, 1'b0, 2'd1},  // R9 cmd ignored asleep
    {4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0},  // R8 falls
    {4'b0000, 1'b0, 4'd0, 1'b1, 1'b0, 2'd2},  // R5 command, no halts
    {4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 2'd2},  // R5 hold
    {4'b0100, 1'b0, 4'd0, 1'b0, 1'b0, 2'd2},  // R8 rise no effect
    {4'b0000, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0},  // R8 fall exits cmd
    {4'b0000, 1'b0, 4'd0, 1'b1, 1'b1, 2'd0},  // R7 wake blocks cmd
    {4'b1111, 1'b1, 4'd0, 1'b1, 1'b0, 2'd2},  // R6 cmd beats auto
    {4'b1111, 1'b1, 4'd0, 1'b0, 1'b1, 2'd0},  // R7 wake from cmd
    {4'b1111, 1'b1, 4'd0, 1'b0, 1'b1, 2'd0},  // R7 wake blocks auto
    {4'b1111, 1'b1, 4'd0, 1'b0, 1'b0, 2'd1},  // R2 enter
    {4'b1111, 1'b0, 4'd0, 1'b0, 1'b0, 2'd1},  // R8 enable clear no exit
    {4'b1111, 1'b0, 4'd0, 1'b0, 1'b1, 2'd0}   // R7 wake
  };

  task automatic chk(input string req, input logic [1:0] exp_mode);
    checks++;
    if (mode_o !== exp_mode || clk_off_o !== (exp_mode != 2'd0)) begin
      errors++;
      $display("FAIL %s mode=%0d clk_off=%0b expected mode=%0d clk_off=%0b",
               req, mode_o, clk_off_o, exp_mode, (exp_mode != 2'd0));
    end
  endtask

  task automatic drive(input logic [12:0] v);
    halt_i     = v[12:9];
    auto_en_i  = v[8];
    dwell_i    = v[7:4];
    sw_sleep_i = v[3];
    wake_i     = v[2];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(13'd0);
    repeat (3) @(negedge clk);
    chk("R1 reset", 2'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      #1;
      chk($sformatf("vector %0d (R2..R11)", i), VEC[i][1:0]);
      @(negedge clk);
    end

    // R2 longest dwell: 15 extra cycles stay active, 16th enters
    drive({4'b1111, 1'b1, 4'd15, 1'b0, 1'b0, 2'd0});
    for (int k = 0; k < 15; k++) begin
      @(posedge clk);
      #1;
      chk("R2 dwell 15 waiting", 2'd0);
    end
    @(posedge clk);
    #1;
    chk("R2 dwell 15 enter", 2'd1);

    // R1 reset during sleep returns to active at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset while asleep", 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(13'd0);
    repeat (4) @(negedge clk);
    chk("R1 active after second reset", 2'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule